// File: doc/BRIEF.md
# Power-Management Control Register Bank

This block is the software-visible register bank of a chip's power-management unit. It sits on a 32-bit word bus and holds the settings for oscillator control, power-mode configuration, wakeup masking and status, stabilisation counts, body-bias and skew control, PHY and converter control, a set of general information words and the power-hold word. Five status and monitor registers are read-only. Any other offset in the 32 KB window is undefined.

Requests arrive on a valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Every accepted request, read or write, produces exactly one response on a valid/ready channel one cycle later. The response register holds a single entry. `req_ready` is high when that entry is empty or is being taken in the same cycle (`rsp_ready` high), so a stalled consumer stalls new requests. There is no other buffering.

Illegal accesses set a sticky error flag. Software clears the flag through a dedicated input. When software writes the power-hold word with its hold bit cleared, the block raises a one-cycle shutdown request.

Top module: `pmu_reg_bank`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request gives `rsp_valid` high on the following cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values.
- R2: After reset, these registers read the following values:
  - operating-mode status (0xE100): 0
  - converter control (0xE810): 0x00000001
  - stop-memory config (0xC034): 0x000000FF
  - clamp settle (0xC114): 0x03FF03FF
  - power hold (0xE81C): 0x00005301
  - display-link control (0xE804): 0x00960000
  - oscillator control (0x8000): 0x00000003
  - idle config (0xC020): 0x60000000
  - block-power status (0xC204): 0x000000BF
  - stop config (0xC030): 0x96000000
  - oscillator settle (0xC104): 0x000FFFFF
  - run config (0xC010): 0xFFFFFFBF
  - reset cause (0xA000): 0x00000001
  - oscillator frequency (0xC100): 0x0000000F
  - memory-timing settle (0xC110): 0xFFFFFFFF
  - bias control (0xC300): 0x00000606
  - image-engine control (0xE800): 0x00000001
- R3: Every register not listed in R2 resets to zero.
- R4: A write to a writable register stores all 32 bits of the write data. A later read returns that value.
- R5: The decoded offset is `req_addr + 0x8000`, where `req_addr` is a 15-bit byte offset. The map by decoded offset is:
  - oscillator registers 0x8000, 0xC100, 0xC104
  - reset cause 0xA000
  - power settings 0xC000 to 0xC00C in steps of 4
  - mode configs 0xC010, 0xC020, 0xC030, 0xC034, 0xC040
  - settle counts 0xC108, 0xC110, 0xC114
  - wakeup status 0xC200
  - block status 0xC204
  - bias and skew registers 0xC300, 0xC310, 0xC314, 0xC320, 0xC324
  - misc 0xE000
  - mode status 0xE100
  - PHY and converter controls 0xE800, 0xE804, 0xE80C, 0xE810, 0xE814, 0xE818
  - power hold 0xE81C
  - information words from 0xF000, one every 4 bytes, `INFO_N` in total
- R6: The read-only registers are 0xA000, 0xC204, 0xC314, 0xC324 and 0xE100. A write to any of them leaves its value unchanged and sets the error flag.
- R7: An access to an offset outside R5's map, including any offset not a multiple of 4, sets the error flag. A read of such an offset returns 0. A write to it changes no register.
- R8: The error flag is sticky. It clears in the cycle after `err_clr` is high. If a new error occurs in the same cycle as `err_clr`, the flag stays set.
- R9: An accepted write to the power-hold register whose bit `HOLD_BIT` (default 8) is 0 drives `shutdown_req` high for exactly the next cycle. If that bit is 1, no pulse is produced. In both cases the value is stored.
- R10: A write response carries `rsp_data` equal to 0. Reads of read-only registers return their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read data, or 0 for writes and undefined offsets |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky access-error flag |
| shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The bench builds the block with `INFO_N` = 8 and `HOLD_BIT` = 8. With these values the last information word sits at decoded offset 0xF01C, so the first offset past the table (0xF020) can be probed as an undefined boundary. The power-hold reset value 0x5301 has the hold bit set, so writing the reset value back must not produce a shutdown. Holding `rsp_ready` low brings the stalled-response path within reach, where a second request waits without being accepted.

// File: rtl/pmu_regs_pkg.sv
package pmu_regs_pkg;

  localparam int ADDR_W   = 15;
  localparam int DEC_W    = ADDR_W + 1;
  localparam int DATA_W   = 32;
  localparam int FIXED_N  = 32;
  localparam int HOLD_IDX = 31;
  localparam logic [DEC_W-1:0] INFO_BASE = 16'hF000;

  typedef struct packed {
    logic [DEC_W-1:0]  off;
    logic [DATA_W-1:0] rst;
    logic              ro;
  } reg_desc_t;

  function automatic reg_desc_t mk(input logic [DEC_W-1:0] o,
                                   input logic [DATA_W-1:0] r,
                                   input logic ro);
    reg_desc_t d;
    d.off = o;
    d.rst = r;
    d.ro  = ro;
    return d;
  endfunction

  // Register table: index -> decoded offset, reset value, read-only.
  function automatic reg_desc_t reg_desc(input int idx);
    case (idx)
      0:  return mk(16'h8000, 32'h0000_0003, 1'b0); // oscillator control
      1:  return mk(16'hA000, 32'h0000_0001, 1'b1); // reset cause
      2:  return mk(16'hC000, 32'h0000_0000, 1'b0); // power settings
      3:  return mk(16'hC004, 32'h0000_0000, 1'b0); // ext wake mask
      4:  return mk(16'hC008, 32'h0000_0000, 1'b0); // wake mask
      5:  return mk(16'hC00C, 32'h0000_0000, 1'b0); // mode select
      6:  return mk(16'hC010, 32'hFFFF_FFBF, 1'b0); // run config
      7:  return mk(16'hC020, 32'h6000_0000, 1'b0); // idle config
      8:  return mk(16'hC030, 32'h9600_0000, 1'b0); // stop config
      9:  return mk(16'hC034, 32'h0000_00FF, 1'b0); // stop memory config
      10: return mk(16'hC040, 32'h0000_0000, 1'b0); // sleep config
      11: return mk(16'hC100, 32'h0000_000F, 1'b0); // oscillator frequency
      12: return mk(16'hC104, 32'h000F_FFFF, 1'b0); // oscillator settle
      13: return mk(16'hC108, 32'h0000_0000, 1'b0); // power settle
      14: return mk(16'hC110, 32'hFFFF_FFFF, 1'b0); // memory-timing settle
      15: return mk(16'hC114, 32'h03FF_03FF, 1'b0); // clamp settle
      16: return mk(16'hC200, 32'h0000_0000, 1'b0); // wakeup status
      17: return mk(16'hC204, 32'h0000_00BF, 1'b1); // block status
      18: return mk(16'hC300, 32'h0000_0606, 1'b0); // bias control
      19: return mk(16'hC310, 32'h0000_0000, 1'b0); // on-skew control
      20: return mk(16'hC314, 32'h0000_0000, 1'b1); // on-skew monitor
      21: return mk(16'hC320, 32'h0000_0000, 1'b0); // off-skew control
      22: return mk(16'hC324, 32'h0000_0000, 1'b1); // off-skew monitor
      23: return mk(16'hE000, 32'h0000_0000, 1'b0); // misc
      24: return mk(16'hE100, 32'h0000_0000, 1'b1); // mode status
      25: return mk(16'hE800, 32'h0000_0001, 1'b0); // image-engine control
      26: return mk(16'hE804, 32'h0096_0000, 1'b0); // display-link control
      27: return mk(16'hE80C, 32'h0000_0000, 1'b0); // usb phy control
      28: return mk(16'hE810, 32'h0000_0001, 1'b0); // converter control
      29: return mk(16'hE814, 32'h0000_0000, 1'b0); // serial phy control
      30: return mk(16'hE818, 32'h0000_0000, 1'b0); // adc control
      31: return mk(16'hE81C, 32'h0000_5301, 1'b0); // power hold
      default: return mk(INFO_BASE + DEC_W'(4 * (idx - FIXED_N)), '0, 1'b0);
    endcase
  endfunction

endpackage

// File: rtl/pmu_addr_decode.sv
module pmu_addr_decode
  import pmu_regs_pkg::*;
#(
  parameter int NREG  = 40,
  parameter int IDX_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              ro
);

  logic [DEC_W-1:0] dec_addr;
  logic [NREG-1:0]  match;
  logic [NREG-1:0]  ro_vec;

  // Window offset plus the window base gives the decoded offset.
  assign dec_addr = {1'b1, addr};

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    localparam reg_desc_t D = reg_desc(i);
    assign match[i]  = (dec_addr == D.off);
    assign ro_vec[i] = D.ro;
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign ro = hit && ro_vec[idx];

endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile
  import pmu_regs_pkg::*;
#(
  parameter int NREG  = 40,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] hold_word
);

  logic [DATA_W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam reg_desc_t D = reg_desc(i);
    if (D.ro) begin : g_ro
      // Status and monitor values: fixed, never written.
      assign q[i] = D.rst;
    end else begin : g_rw
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= D.rst;
        else if (wr_en && (wr_idx == IDX_W'(i))) r <= wr_data;
      end
      assign q[i] = r;
    end
  end

  assign rd_data   = q[rd_idx];
  assign hold_word = q[HOLD_IDX];

endmodule

// File: rtl/pmu_bus_resp.sv
module pmu_bus_resp
  import pmu_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              rsp_ready,
  input  logic              dec_hit,
  input  logic              dec_ro,
  input  logic              is_hold,
  input  logic              hold_bit_wr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              err_clr,
  output logic              req_ready,
  output logic              wr_en,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_flag,
  output logic              shutdown_req
);

  logic acc;
  logic err_set;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_en     = acc && req_we && dec_hit && !dec_ro;
  assign err_set   = acc && (!dec_hit || (req_we && dec_ro));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (!req_we && dec_hit) ? rd_data : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (err_set) err_flag <= 1'b1;
    else if (err_clr) err_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shutdown_req <= 1'b0;
    else        shutdown_req <= acc && req_we && is_hold && !hold_bit_wr;
  end

  assert_rsp_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  assert_ro_write_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_we && dec_ro |=> err_flag);

  assert_undef_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !dec_hit |=> rsp_valid && (rsp_data == '0) && err_flag);

endmodule

// File: rtl/pmu_reg_bank.sv
module pmu_reg_bank
  import pmu_regs_pkg::*;
#(
  parameter int INFO_N   = 8,
  parameter int HOLD_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              shutdown_req
);

  localparam int NREG  = FIXED_N + INFO_N;
  localparam int IDX_W = $clog2(NREG);

  logic              dec_hit;
  logic              dec_ro;
  logic [IDX_W-1:0]  dec_idx;
  logic              wr_en;
  logic              is_hold;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] hold_word;

  pmu_addr_decode #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
    .addr (req_addr),
    .hit  (dec_hit),
    .idx  (dec_idx),
    .ro   (dec_ro)
  );

  pmu_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (dec_idx),
    .wr_data   (req_wdata),
    .rd_idx    (dec_idx),
    .rd_data   (rd_data),
    .hold_word (hold_word)
  );

  assign is_hold = dec_hit && (dec_idx == IDX_W'(HOLD_IDX));

  pmu_bus_resp u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_we       (req_we),
    .rsp_ready    (rsp_ready),
    .dec_hit      (dec_hit),
    .dec_ro       (dec_ro),
    .is_hold      (is_hold),
    .hold_bit_wr  (req_wdata[HOLD_BIT]),
    .rd_data      (rd_data),
    .err_clr      (err_clr),
    .req_ready    (req_ready),
    .wr_en        (wr_en),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .err_flag     (err_flag),
    .shutdown_req (shutdown_req)
  );

  // A shutdown pulse only follows a stored hold word with the bit cleared.
  assert_shut_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> !hold_word[HOLD_BIT]);

endmodule

// File: tb/tb_pmu_reg_bank.sv
module tb_pmu_reg_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        err_clr = 1'b0;
  logic        err_flag;
  logic        shutdown_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  pmu_reg_bank #(.INFO_N(8), .HOLD_BIT(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .err_clr(err_clr), .err_flag(err_flag), .shutdown_req(shutdown_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mem [int];
  bit          rom [int];
  bit          m_rv, m_err, m_shut;
  logic [31:0] m_rd;

  function automatic void put(input int k, input logic [31:0] v, input bit r);
    mem[k] = v;
    rom[k] = r;
  endfunction

  function automatic void m_reset();
    mem.delete();
    rom.delete();
    put('h0000, 32'h3, 0);         put('h2000, 32'h1, 1);
    put('h4000, 0, 0); put('h4004, 0, 0); put('h4008, 0, 0); put('h400C, 0, 0);
    put('h4010, 32'hFFFFFFBF, 0);  put('h4020, 32'h60000000, 0);
    put('h4030, 32'h96000000, 0);  put('h4034, 32'hFF, 0);
    put('h4040, 0, 0);             put('h4100, 32'hF, 0);
    put('h4104, 32'hFFFFF, 0);     put('h4108, 0, 0);
    put('h4110, 32'hFFFFFFFF, 0);  put('h4114, 32'h03FF03FF, 0);
    put('h4200, 0, 0);             put('h4204, 32'hBF, 1);
    put('h4300, 32'h606, 0);       put('h4310, 0, 0);
    put('h4314, 0, 1);             put('h4320, 0, 0);
    put('h4324, 0, 1);             put('h6000, 0, 0);
    put('h6100, 0, 1);             put('h6800, 32'h1, 0);
    put('h6804, 32'h00960000, 0);  put('h680C, 0, 0);
    put('h6810, 32'h1, 0);         put('h6814, 0, 0);
    put('h6818, 0, 0);             put('h681C, 32'h5301, 0);
    for (int i = 0; i < 8; i++) put('h7000 + 4 * i, 0, 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset();
      m_rv = 0; m_rd = 0; m_err = 0; m_shut = 0;
    end else begin
      bit acc, known;
      int key;
      key   = int'(req_addr);
      acc   = req_valid && (!m_rv || rsp_ready);
      known = mem.exists(key);
      m_shut = acc && req_we && (key == 'h681C) && !req_wdata[8];
      if (acc && (!known || (req_we && rom[key]))) m_err = 1;
      else if (err_clr) m_err = 0;
      if (acc) begin
        m_rv = 1;
        m_rd = (!req_we && known) ? mem[key] : 32'h0;
        if (req_we && known && !rom[key]) mem[key] = req_wdata;
      end else if (rsp_ready) begin
        m_rv = 0;
      end
    end
  end

  // Compare every cycle, well away from the active edge.
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      chk("R1 req_ready", 32'(req_ready), 32'(!m_rv || rsp_ready));
      chk("R1 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) chk("R4 rsp_data", rsp_data, m_rd);
      chk("R8 err_flag", 32'(err_flag), 32'(m_err));
      chk("R9 shutdown_req", 32'(shutdown_req), 32'(m_shut));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic xfer(input bit we, input logic [14:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    rd = rsp_data;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R8 reset err_flag", 32'(err_flag), 0);
    chk("R9 reset shutdown_req", 32'(shutdown_req), 0);

    // R2 / R5: reset values through the decoded map
    xfer(0, 15'h0000, 0, v); chk("R2 osc ctl", v, 32'h3);
    xfer(0, 15'h2000, 0, v); chk("R2 reset cause", v, 32'h1);
    xfer(0, 15'h4010, 0, v); chk("R2 run cfg", v, 32'hFFFFFFBF);
    xfer(0, 15'h4030, 0, v); chk("R2 stop cfg", v, 32'h96000000);
    xfer(0, 15'h4110, 0, v); chk("R5 mtc settle", v, 32'hFFFFFFFF);
    xfer(0, 15'h4114, 0, v); chk("R2 clamp", v, 32'h03FF03FF);
    xfer(0, 15'h4204, 0, v); chk("R2 blk status", v, 32'hBF);
    xfer(0, 15'h6804, 0, v); chk("R2 display", v, 32'h00960000);
    xfer(0, 15'h681C, 0, v); chk("R2 hold", v, 32'h5301);
    // R3: unlisted registers reset to zero
    xfer(0, 15'h4000, 0, v); chk("R3 pwr cfg", v, 0);
    xfer(0, 15'h701C, 0, v); chk("R3 info7", v, 0);
    chk("R3 no error", 32'(err_flag), 0);

    // R4: full-width write and read-back
    xfer(1, 15'h700C, 32'hA5A55A5A, v); chk("R10 write rsp zero", v, 0);
    xfer(0, 15'h700C, 0, v); chk("R4 info3", v, 32'hA5A55A5A);
    xfer(1, 15'h4008, 32'hFFFFFFFF, v);
    xfer(0, 15'h4008, 0, v); chk("R4 wake mask ones", v, 32'hFFFFFFFF);
    xfer(1, 15'h4008, 32'h0, v);
    xfer(0, 15'h4008, 0, v); chk("R4 wake mask zero", v, 0);

    // R6: read-only writes
    xfer(1, 15'h2000, 32'hDEADBEEF, v);
    chk("R6 err after ro write", 32'(err_flag), 1);
    xfer(0, 15'h2000, 0, v); chk("R6 reset cause kept", v, 32'h1);
    clear_err();
    chk("R8 cleared", 32'(err_flag), 0);
    xfer(1, 15'h4204, 32'h0, v);
    xfer(0, 15'h4204, 0, v); chk("R6 blk status kept", v, 32'hBF);
    chk("R6 err again", 32'(err_flag), 1);
    clear_err();

    // R7: undefined offsets
    xfer(0, 15'h4018, 0, v); chk("R7 undefined read zero", v, 0);
    chk("R7 err undefined", 32'(err_flag), 1);
    clear_err();
    xfer(0, 15'h7020, 0, v); chk("R7 past info read zero", v, 0);
    chk("R7 err past info", 32'(err_flag), 1);
    clear_err();
    xfer(1, 15'h4012, 32'h12345678, v);
    chk("R7 err misaligned", 32'(err_flag), 1);
    xfer(0, 15'h4010, 0, v); chk("R7 neighbour untouched", v, 32'hFFFFFFBF);

    // R8: set wins over clear in the same cycle
    clear_err();
    @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 15'h6100; req_wdata = 32'h1; err_clr = 1;
    @(negedge clk);
    req_valid = 0; req_we = 0; err_clr = 0;
    chk("R8 set beats clear", 32'(err_flag), 1);
    @(negedge clk);
    chk("R8 sticky", 32'(err_flag), 1);
    clear_err();

    // R9: shutdown pulse
    xfer(1, 15'h681C, 32'h5301, v);
    chk("R9 no pulse with bit set", 32'(shutdown_req), 0);
    xfer(1, 15'h681C, 32'h5201, v);
    chk("R9 pulse", 32'(shutdown_req), 1);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(shutdown_req), 0);
    xfer(0, 15'h681C, 0, v); chk("R9 hold stored", v, 32'h5201);

    // R1: back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_we = 0; req_addr = 15'h0000;
    @(negedge clk);
    req_addr = 15'h4010;
    for (int i = 0; i < 3; i++) begin
      chk("R1 stalled data", rsp_data, 32'h3);
      chk("R1 stalled ready", 32'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R1 second response", rsp_data, 32'hFFFFFFBF);
    @(negedge clk);
    chk("R1 drained", 32'(rsp_valid), 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule